// File: doc/BRIEF.md
# Touch-Panel Sampling Register Block

This block is the register face of a touch-panel sampling controller. A stimulus port supplies a pen-contact level and raw 15-bit X and Y positions. While touch sampling is enabled, the block scales both positions to a 0..4096 range, follows the pen-contact level, and records pen-down and pen-up transitions as sticky status bits. The CPU reaches it over a simple register bus with an address, a write enable, a read strobe, 32-bit write data and combinational read data. A level interrupt is raised whenever an enabled status bit is set and stays up until software clears or masks that bit.

Coordinates are returned through a touch-data register whose reads alternate. The first read gives a word holding both scaled positions. The second read gives a fixed marker word and rearms the sequence. The configuration, same-point and wait registers are storage only. No conversion timing, analog front end or auxiliary sampling path is modelled.

Top module: `tpadc_regs`

## Requirements
- R1: After synchronous reset these read as zero: the enable (0x00), interrupt mask (0x08), status (0x0C), same (0x10) and wait (0x14) registers. `irq` is low, the first touch-data read (0x18) returns 0, and the pen is taken to be up.
- R2: The enable register (0x00) keeps write data bits 2:0, and bit 2 is the touch enable. While bit 2 is 0, the pen input changes no status bit, the stored coordinates stay frozen, and `irq` is low.
- R3: The interrupt mask register (0x08) keeps write data bits 4:0. A write to status (0x0C) clears each status bit whose write data bit is 1. Status bits are otherwise sticky.
- R4: With touch enabled, a pen-up to pen-down transition sets status bits 4 and 2 (0x14). A pen-down to pen-up transition sets bits 3 and 2 (0x0C).
- R5: `irq` equals touch enable AND (mask & status != 0) as a level. It drops in the cycle after the matching bits are cleared or masked.
- R6: Each raw coordinate v is scaled to floor(v*4096/32767), giving 0..4096. The value is captured on every clock while touch is enabled.
- R7: A read of touch data (0x18) first returns {3'b0, Y[12:0], 3'b0, X[12:0]}, that is X in bits 12:0 and Y in bits 28:16. The next read returns 0x00003FFF and rearms the sequence. The sequence advances only on a read strobe to 0x18.
- R8: The configuration register (0x04) resets to 0x0002002C and keeps only the write data bits in mask 0xC007FFFF.
- R9: The same (0x10) and wait (0x14) registers store write data bits 15:0 and read them back.
- R10: When a pen edge and a status-clear write fall in the same cycle, the bits set by the edge survive the clear.
- R11: Because the pen resets to up, enabling touch while the pen is already down produces a pen-down event on the first enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (advances the touch-data sequence) |
| bus_rdata | output | 32 | Read data for bus_addr |
| pen_down | input | 1 | Pen-contact level, 1 = touching |
| pen_x | input | 15 | Raw X position |
| pen_y | input | 15 | Raw Y position |
| irq | output | 1 | Level interrupt |

## Verification
A wrong pen-state register shows up at the status read one clock after the pen input moves. A missed edge leaves the status at zero, and a spurious edge sets 0x14 or 0x0C where none is due. Either one moves `irq` in that same cycle once the mask is open. A wrong touch-data phase shows on the very next read of 0x18, because the marker and the coordinate word trade places. Clear-versus-set ordering and the frozen-while-disabled behaviour are each probed in the cycle right after the stimulus.

// File: rtl/tpadc_pkg.sv
package tpadc_pkg;

    localparam int RAW_W  = 15;
    localparam int SCL_W  = 13;
    localparam int STAT_W = 5;
    localparam int EN_W   = 3;
    localparam int TCH_EN_BIT = 2;

    localparam logic [7:0] A_ENABLE = 8'h00;
    localparam logic [7:0] A_CONFIG = 8'h04;
    localparam logic [7:0] A_MASK   = 8'h08;
    localparam logic [7:0] A_STATUS = 8'h0C;
    localparam logic [7:0] A_SAME   = 8'h10;
    localparam logic [7:0] A_WAIT   = 8'h14;
    localparam logic [7:0] A_TDATA  = 8'h18;

    localparam logic [31:0] CFG_RESET = 32'h0002_002C;
    localparam logic [31:0] CFG_KEEP  = 32'hC007_FFFF;
    localparam logic [31:0] TD_MARKER = 32'h0000_3FFF;

    localparam logic [STAT_W-1:0] ST_PEN_DN = 5'h14;
    localparam logic [STAT_W-1:0] ST_PEN_UP = 5'h0C;

    typedef struct packed {
        logic went_down;
        logic went_up;
    } pen_evt_t;

    typedef enum logic {
        TD_COORD  = 1'b0,
        TD_MARK   = 1'b1
    } td_phase_e;

    function automatic logic [SCL_W-1:0] scale_coord(input logic [RAW_W-1:0] v);
        logic [RAW_W+12:0] prod;
        logic [RAW_W+12:0] quo;
        prod = {13'd0, v} << 12;
        quo  = prod / (RAW_W+13)'(32767);
        return quo[SCL_W-1:0];
    endfunction

endpackage

// File: rtl/tpadc_scale.sv
module tpadc_scale
    import tpadc_pkg::*;
(
    input  logic [RAW_W-1:0] raw,
    output logic [SCL_W-1:0] scaled
);
    always_comb scaled = scale_coord(raw);
endmodule

// File: rtl/tpadc_pen_event.sv
module tpadc_pen_event
    import tpadc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     touch_en,
    input  logic     pen_down,
    output pen_evt_t evt
);
    logic pen_q;

    always_ff @(posedge clk) begin
        if (rst)           pen_q <= 1'b0;
        else if (touch_en) pen_q <= pen_down;
    end

    always_comb begin
        evt.went_down = touch_en &  pen_down & ~pen_q;
        evt.went_up   = touch_en & ~pen_down &  pen_q;
    end

    AST_PEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !touch_en |=> $stable(pen_q)); // R2
endmodule

// File: rtl/tpadc_status.sv
module tpadc_status
    import tpadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              touch_en,
    input  logic [STAT_W-1:0] irq_mask,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_bits,
    input  pen_evt_t          evt,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] kill_bits;

    always_comb begin
        set_bits  = (evt.went_down ? ST_PEN_DN : '0) | (evt.went_up ? ST_PEN_UP : '0);
        kill_bits = clr_wr ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~kill_bits) | set_bits;
    end

    always_comb irq = touch_en & (|(irq_mask & status));

    AST_DOWN_SETS: assert property (@(posedge clk) disable iff (rst)
        evt.went_down |=> ((status & ST_PEN_DN) == ST_PEN_DN)); // R4
    AST_UP_SETS: assert property (@(posedge clk) disable iff (rst)
        evt.went_up |=> ((status & ST_PEN_UP) == ST_PEN_UP)); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !evt.went_down && !evt.went_up) |=> ((status & $past(clr_bits)) == '0)); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && !evt.went_down && !evt.went_up) |=> $stable(status)); // R3
    AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && (evt.went_down || evt.went_up)) |=> status[2]); // R10
endmodule

// File: rtl/tpadc_regs.sv
module tpadc_regs
    import tpadc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pen_down,
    input  logic [RAW_W-1:0]  pen_x,
    input  logic [RAW_W-1:0]  pen_y,
    output logic              irq
);
    localparam int AXES  = 2;
    localparam int Y_LSB = 16;

    logic [EN_W-1:0]   enable_q;
    logic [DATA_W-1:0] config_q;
    logic [STAT_W-1:0] mask_q;
    logic [15:0]       same_q;
    logic [15:0]       wait_q;
    logic [SCL_W-1:0]  coord_q  [AXES];
    logic [RAW_W-1:0]  raw_ax   [AXES];
    logic [SCL_W-1:0]  scl_ax   [AXES];
    td_phase_e         phase_q;

    logic              touch_en;
    logic              rd_tdata;
    logic [STAT_W-1:0] status;
    pen_evt_t          evt;

    always_comb begin
        touch_en  = enable_q[TCH_EN_BIT];
        rd_tdata  = bus_rd && (bus_addr == ADDR_W'(A_TDATA));
        raw_ax[0] = pen_x;
        raw_ax[1] = pen_y;
    end

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        tpadc_scale u_scale (.raw(raw_ax[a]), .scaled(scl_ax[a]));

        always_ff @(posedge clk) begin
            if (rst)           coord_q[a] <= '0;
            else if (touch_en) coord_q[a] <= scl_ax[a];
        end
    end

    tpadc_pen_event u_pen (
        .clk(clk), .rst(rst), .touch_en(touch_en),
        .pen_down(pen_down), .evt(evt)
    );

    tpadc_status u_stat (
        .clk(clk), .rst(rst), .touch_en(touch_en), .irq_mask(mask_q),
        .clr_wr(bus_wr && (bus_addr == ADDR_W'(A_STATUS))),
        .clr_bits(bus_wdata[STAT_W-1:0]), .evt(evt),
        .status(status), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            config_q <= DATA_W'(CFG_RESET);
            mask_q   <= '0;
            same_q   <= '0;
            wait_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(A_ENABLE): enable_q <= bus_wdata[EN_W-1:0];
                ADDR_W'(A_CONFIG): config_q <= bus_wdata & DATA_W'(CFG_KEEP);
                ADDR_W'(A_MASK):   mask_q   <= bus_wdata[STAT_W-1:0];
                ADDR_W'(A_SAME):   same_q   <= bus_wdata[15:0];
                ADDR_W'(A_WAIT):   wait_q   <= bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           phase_q <= TD_COORD;
        else if (rd_tdata) phase_q <= (phase_q == TD_COORD) ? TD_MARK : TD_COORD;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_ENABLE): bus_rdata = DATA_W'(enable_q);
            ADDR_W'(A_CONFIG): bus_rdata = config_q;
            ADDR_W'(A_MASK):   bus_rdata = DATA_W'(mask_q);
            ADDR_W'(A_STATUS): bus_rdata = DATA_W'(status);
            ADDR_W'(A_SAME):   bus_rdata = DATA_W'(same_q);
            ADDR_W'(A_WAIT):   bus_rdata = DATA_W'(wait_q);
            ADDR_W'(A_TDATA):  bus_rdata = (phase_q == TD_COORD)
                                 ? ((DATA_W'(coord_q[1]) << Y_LSB) | DATA_W'(coord_q[0]))
                                 : DATA_W'(TD_MARKER);
            default: ;
        endcase
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        rd_tdata |=> (phase_q != $past(phase_q))); // R7
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_tdata |=> $stable(phase_q)); // R7
    AST_COORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !touch_en |=> ($stable(coord_q[0]) && $stable(coord_q[1]))); // R2
endmodule

// File: tb/tpadc_regs_bench.sv
`timescale 1ns/1ps
module tpadc_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        pen_down = 1'b0;
    logic [14:0] pen_x = '0;
    logic [14:0] pen_y = '0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tpadc_regs u_tpadc_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pen_down(pen_down), .pen_x(pen_x), .pen_y(pen_y), .irq(irq)
    );

    localparam int NVEC = 8;
    localparam logic [29:0] SCALE_VEC [NVEC] = '{
        {15'd0,     15'h7FFF},
        {15'h7FFF,  15'd0},
        {15'd1,     15'd8},
        {15'd16383, 15'd16384},
        {15'd1000,  15'd24000},
        {15'd32766, 15'd4095},
        {15'd12345, 15'd7},
        {15'd20000, 15'd30000}
    };

    function automatic logic [31:0] expect_scale(input logic [14:0] v);
        longint p;
        p = longint'(v) * 4096;
        return 32'(p / 32767);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); check("R1 enable", d, 32'h0);
        rd(8'h04, d); check("R8 config reset", d, 32'h0002002C);
        rd(8'h08, d); check("R1 mask", d, 32'h0);
        rd(8'h0C, d); check("R1 status", d, 32'h0);
        rd(8'h10, d); check("R1 same", d, 32'h0);
        rd(8'h14, d); check("R1 wait", d, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        rd(8'h18, d); check("R1 touch data first", d, 32'h0);
        rd(8'h18, d); check("R7 marker after reset", d, 32'h3FFF);

        // R8 config write mask
        wr(8'h04, 32'hFFFFFFFF);
        rd(8'h04, d); check("R8 config mask", d, 32'hC007FFFF);

        // R2 enable width; touch disabled ignores pen
        wr(8'h00, 32'hFF);
        rd(8'h00, d); check("R2 enable width", d, 32'h7);
        wr(8'h00, 32'h3);
        wr(8'h08, 32'h1F);
        pen_down = 1'b1; pen_x = 15'd1000; pen_y = 15'd2000;
        idle(3);
        rd(8'h0C, d); check("R2 no status while disabled", d, 32'h0);
        check("R2 irq low while disabled", {31'd0, irq}, 32'h0);
        rd(8'h18, d); check("R2 coords frozen", d, 32'h0);
        rd(8'h18, d); check("R7 marker", d, 32'h3FFF);

        // R11 enable with pen already down
        wr(8'h00, 32'h4);
        idle(1);
        rd(8'h0C, d); check("R11 pen-down on enable", d, 32'h14);
        check("R5 irq high", {31'd0, irq}, 32'h1);

        // R3 / R5 clear and mask
        wr(8'h0C, 32'h10);
        rd(8'h0C, d); check("R3 partial clear", d, 32'h04);
        check("R5 irq still high", {31'd0, irq}, 32'h1);
        wr(8'h08, 32'h10);
        check("R5 irq masked", {31'd0, irq}, 32'h0);
        wr(8'h08, 32'hFF);
        rd(8'h08, d); check("R3 mask width", d, 32'h1F);
        check("R5 irq unmasked", {31'd0, irq}, 32'h1);
        wr(8'h0C, 32'h04);
        check("R5 irq after clear", {31'd0, irq}, 32'h0);
        rd(8'h0C, d); check("R3 full clear", d, 32'h0);

        // R4 pen-up edge
        @(negedge clk); pen_down = 1'b0;
        idle(1);
        rd(8'h0C, d); check("R4 pen-up sets 0x0C", d, 32'h0C);
        idle(3);
        rd(8'h0C, d); check("R3 sticky", d, 32'h0C);

        // R10 edge and clear same cycle
        @(negedge clk);
        pen_down = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1F; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(8'h0C, d); check("R10 edge beats clear", d, 32'h14);

        // R2 disable gates irq and freezes status
        check("R5 irq before disable", {31'd0, irq}, 32'h1);
        wr(8'h00, 32'h0);
        check("R2 irq gated by enable", {31'd0, irq}, 32'h0);
        @(negedge clk); pen_down = 1'b0;
        idle(2);
        rd(8'h0C, d); check("R2 pen-up ignored", d, 32'h14);
        wr(8'h0C, 32'h1F);
        wr(8'h00, 32'h4);

        // R7 sequence only on read strobe
        pen_x = 15'd16384; pen_y = 15'd8;
        idle(1);
        rd(8'h18, d); check("R7 coord word", d, (expect_scale(15'd8) << 16) | expect_scale(15'd16384));
        idle(5);
        rd(8'h10, d);
        rd(8'h18, d); check("R7 idle does not advance", d, 32'h3FFF);
        rd(8'h18, d); check("R7 rearmed", d, (expect_scale(15'd8) << 16) | expect_scale(15'd16384));
        rd(8'h18, d);

        // R6 scaling table
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] vx;
            logic [14:0] vy;
            vx = SCALE_VEC[i][29:15];
            vy = SCALE_VEC[i][14:0];
            @(negedge clk); pen_x = vx; pen_y = vy;
            idle(1);
            rd(8'h18, d); check("R6 scaled coords", d, (expect_scale(vy) << 16) | expect_scale(vx));
            rd(8'h18, d); check("R7 marker in table", d, 32'h3FFF);
        end
        @(negedge clk); pen_x = 15'h7FFF; pen_y = 15'h7FFF;
        idle(1);
        rd(8'h18, d); check("R6 full scale 4096", d, 32'h1000_1000);
        rd(8'h18, d);

        // R9 plain storage
        wr(8'h10, 32'h1234ABCD);
        wr(8'h14, 32'hFFFF5A5A);
        rd(8'h10, d); check("R9 same", d, 32'h0000ABCD);
        rd(8'h14, d); check("R9 wait", d, 32'h00005A5A);

        // R1 reset again restores state
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(8'h04, d); check("R8 config after reset", d, 32'h0002002C);
        rd(8'h10, d); check("R1 same after reset", d, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule